// File: doc/BRIEF.md
# Circular Sample Delay Buffer

This block delays a stream of audio samples by almost one full memory length. Each time the sample-valid strobe is high, the incoming sample is written into a circular memory. In the same clock, the slot just past the write position is read. That slot holds the oldest sample still stored. The read value reaches the output one clock later and is held there until the next strobe. With the deployment address width of 13 bits, the memory has 8192 entries, which gives a long fixed echo or delay line.

Two address counters move together around the memory. The write counter starts at slot 0 and the read counter at slot 1, so the read counter always stays exactly one slot ahead. Both counters wrap from the last slot back to slot 0. Reset clears the counters and the output register, but it leaves the stored samples in place.

Top module: `dlybuf_top`

## Requirements
- R1: The memory holds 2**ADDR_W samples of DATA_W bits each. The deployment setting is ADDR_W = 13 and DATA_W = 16, which gives 8192 entries.
- R2: While rst is high (synchronous, active high), smp_out is 0, the write slot is reset to 0 and the read slot is reset to 1. The first strobe after reset therefore writes slot 0 and outputs the contents of slot 1.
- R3: On a clock edge where smp_valid is high and rst is low, smp_in is stored at the current write slot, and both slots then advance by one.
- R4: The read slot always equals the write slot plus one, modulo the memory depth.
- R5: On a clock edge where smp_valid is high, the contents of the read slot are captured, and smp_out shows them from that edge on. This is a latency of one clock after the address is presented.
- R6: On a clock edge where smp_valid is low, smp_out and both slots keep their values.
- R7: Once a slot has been written since the memory was first filled, the output of the strobe that carries sample n equals sample n-(2**ADDR_W-1).
- R8: Both slots wrap from 2**ADDR_W-1 to 0.
- R9: Reset does not clear the stored samples, and a strobe that arrives while rst is high writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe: writes one sample and captures one delayed sample |
| smp_in | input | DATA_W | Incoming sample |
| smp_out | output | DATA_W | Delayed sample, held between strobes |

## Verification
The bench builds the block with ADDR_W = 4, which gives a 16-entry memory. With that depth, filling the memory, wrapping both slots several times and observing the 15-strobe delay all take only a few dozen strobes. The bench also applies a reset in the middle of a run, with the strobe held high during the reset. After that, the retained contents and the restarted slot positions can be observed at the output within one more pass of the memory.

// File: rtl/dlybuf_pkg.sv
package dlybuf_pkg;

    // Default geometry. The deployment build overrides the address width to 13.
    localparam int DLY_AW_DEF = 10;
    localparam int DLY_DW_DEF = 16;

    // Number of slots for a given address width.
    function automatic int unsigned depth_of(input int unsigned aw);
        return 32'd1 << aw;
    endfunction

endpackage

// File: rtl/dlybuf_ptrs.sv
module dlybuf_ptrs
    import dlybuf_pkg::*;
#(
    parameter int AW = DLY_AW_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr
);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
    } ptr_pair_t;

    ptr_pair_t ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q.wr <= '0;
            ptr_q.rd <= AW'(1);
        end else if (adv) begin
            // Natural overflow of AW bits wraps both slots around the memory.
            ptr_q.wr <= ptr_q.wr + AW'(1);
            ptr_q.rd <= ptr_q.rd + AW'(1);
        end
    end

    assign wr_addr = ptr_q.wr;
    assign rd_addr = ptr_q.rd;

endmodule

// File: rtl/dlybuf_ram.sv
module dlybuf_ram
    import dlybuf_pkg::*;
#(
    parameter int AW = DLY_AW_DEF,
    parameter int DW = DLY_DW_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = int'(depth_of(AW));

    logic [DW-1:0] mem [DEPTH];

    // Storage array: no reset, so contents survive a reset.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Registered read port, captured only when a read is requested.
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/dlybuf_top.sv
module dlybuf_top
    import dlybuf_pkg::*;
#(
    parameter int ADDR_W = DLY_AW_DEF,
    parameter int DATA_W = DLY_DW_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_in,
    output logic [DATA_W-1:0] smp_out
);

    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic              step;

    // A strobe during reset is discarded entirely.
    assign step = smp_valid & ~rst;

    dlybuf_ptrs #(
        .AW (ADDR_W)
    ) u_ptrs (
        .clk     (clk),
        .rst     (rst),
        .adv     (step),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr)
    );

    dlybuf_ram #(
        .AW (ADDR_W),
        .DW (DATA_W)
    ) u_ram (
        .clk   (clk),
        .rst   (rst),
        .we    (step),
        .waddr (wr_addr),
        .wdata (smp_in),
        .re    (step),
        .raddr (rd_addr),
        .rdata (smp_out)
    );

endmodule

// File: rtl/dlybuf_chk.sv
module dlybuf_chk #(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic [DW-1:0] dout,
    input logic [AW-1:0] wp,
    input logic [AW-1:0] rp
);

    assert_rst_ptrs_R2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (wp == '0 && rp == AW'(1) && dout == '0));

    assert_lead_R4: assert property (@(posedge clk) disable iff (rst)
        rp == wp + AW'(1));

    assert_adv_R3: assert property (@(posedge clk) disable iff (rst)
        en |=> (wp == $past(wp) + AW'(1)));

    assert_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (en && wp == {AW{1'b1}}) |=> (wp == '0));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(dout) && $stable(wp) && $stable(rp)));

endmodule

bind dlybuf_top dlybuf_chk #(
    .AW (ADDR_W),
    .DW (DATA_W)
) u_chk (
    .clk  (clk),
    .rst  (rst),
    .en   (smp_valid),
    .dout (smp_out),
    .wp   (wr_addr),
    .rp   (rd_addr)
);

// File: tb/sim_dlybuf_top.sv
`timescale 1ns/1ps
module sim_dlybuf_top;

    localparam int AW    = 4;
    localparam int DW    = 16;
    localparam int DEPTH = 16;
    localparam int NTBL  = 20;

    localparam logic [DW-1:0] TBL_D [NTBL] = '{
        16'h0001, 16'h1234, 16'hFFFF, 16'h8000, 16'h7FFF,
        16'h00FF, 16'hFF00, 16'h5555, 16'hAAAA, 16'h0F0F,
        16'hF0F0, 16'h3C3C, 16'hC3C3, 16'h0102, 16'h0304,
        16'hBEEF, 16'hCAFE, 16'h1111, 16'h2222, 16'h9999
    };
    localparam int TBL_GAP [NTBL] = '{
        0, 1, 0, 2, 0, 3, 0, 0, 1, 0,
        2, 0, 0, 1, 0, 2, 0, 3, 1, 0
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wen = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;

    always #2 clk = ~clk;

    dlybuf_top #(
        .ADDR_W (AW),
        .DATA_W (DW)
    ) u0 (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (wen),
        .smp_in    (din),
        .smp_out   (dout)
    );

    int            n_run  = 0;
    int            n_fail = 0;
    logic [DW-1:0] mdl_mem [DEPTH];
    bit            mdl_ok  [DEPTH];
    int            mdl_w   = 0;
    logic [DW-1:0] last_out = '0;

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One strobe; the output is compared one edge later against the model slot.
    task automatic push(input logic [DW-1:0] d, input string tag);
        int ra;
        ra = (mdl_w + 1) % DEPTH;
        @(negedge clk);
        wen = 1'b1;
        din = d;
        @(posedge clk);
        #1;
        if (mdl_ok[ra]) chk(tag, dout, mdl_mem[ra]);
        mdl_mem[mdl_w] = d;
        mdl_ok[mdl_w]  = 1'b1;
        mdl_w          = (mdl_w + 1) % DEPTH;
        last_out       = dout;
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            wen = 1'b0;
            din = 16'h5A5A;
            @(posedge clk);
            #1;
            chk(tag, dout, last_out);
        end
    endtask

    // Reset with the strobe held high: writes during reset must be discarded.
    task automatic do_reset(input int n);
        @(negedge clk);
        rst = 1'b1;
        wen = 1'b1;
        din = 16'hDEAD;
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
            chk("R2 output cleared during reset", dout, '0);
        end
        @(negedge clk);
        rst      = 1'b0;
        wen      = 1'b0;
        mdl_w    = 0;
        last_out = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual run still busy, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // Reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R2 reset output", dout, '0);
        @(negedge clk);
        rst = 1'b0;
        idle(2, "R6 hold after reset");

        // Table walk: fill, then delay of DEPTH-1 strobes
        for (int i = 0; i < NTBL; i++) begin
            push(TBL_D[i], "R1 R5 R7 table delay");
            idle(TBL_GAP[i], "R6 hold between strobes");
        end

        // Back-to-back strobes across several wraps
        for (int i = 0; i < 40; i++) begin
            push(16'hA000 + 16'(i), "R3 R8 burst wrap");
        end
        idle(3, "R6 hold after burst");

        // Mid-run reset with strobe held high
        do_reset(3);
        push(16'h0C01, "R2 R4 R9 first read after reset is slot 1");
        for (int i = 1; i < 18; i++) begin
            push(16'h0C00 + 16'(i), "R9 retained contents and ignored reset writes");
        end
        idle(2, "R6 final hold");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule